// File: doc/BRIEF.md
# Event Timer Register Block

This block is the register front end of a multi-channel event timer. It keeps a 64-bit main counter that advances by one on each tick strobe while the block is enabled. It exposes a fixed capability word and a tick period word, a two-bit general configuration, a status word, and a register window for each comparator channel. Software reaches all of these through 32-bit reads and writes on a plain request/acknowledge bus that covers a 1 KB window.

The block does not do any comparator arithmetic. It gives the downstream comparator logic the live count and each channel's comparator value. It also sends one-cycle arm and cancel strobes when software starts or stops the timer or loads a comparator.

The block chooses an interrupt line number for every channel. When legacy routing is on, channels 0 and 1 go to fixed lines in place of their programmed route fields. A legacy flag output lets neighbouring logic silence the old interval timer and clock interrupts while this timer replaces them.

Top module: `evt_timer_regs`

## Requirements
- R1: Every request cycle is followed, in the next cycle, by `ack` high for exactly one cycle. A read presents its data on `rdata` in that same cycle, and a write's effect is visible from that cycle on. `ack` is never high except in the cycle after a request.
- R2: Offset 0x000 reads 0x8086A201: bit 15 marks legacy routing support, bit 13 marks a 64-bit counter, bits 12:8 hold the channel count minus one, and the low byte is revision 1. Offset 0x004 reads 0x00989680, the tick period of 10 ns in femtoseconds. Writes to 0x000 change nothing.
- R3: In the general configuration at 0x010, only bit 0 (run) and bit 1 (legacy) can be written. All other bits read zero. The word at 0x014 reads zero and ignores writes.
- R4: The main counter, read low word at 0x0F0 and high word at 0x0F4, rises by one per `tick` strobe only while run is set. While run is clear it holds its value, and reads return the held value.
- R5: A write to either counter half replaces only that half and keeps the other half.
- R6: A 0-to-1 write of run pulses `arm` for one cycle, in the ack cycle, for every channel whose comparator is not all ones. Other channels see no pulse.
- R7: A 1-to-0 write of run pulses `cancel` for every channel in the ack cycle, with no `arm`.
- R8: Channel n's comparator sits at 0x108 + n*0x20 (low word) and 0x10C + n*0x20 (high word). A write to either half replaces only that half, clears configuration bit 6, and pulses that channel's `arm` only if run is set.
- R9: Channel configuration at 0x100 + n*0x20 resets to 0x00000030. Only the bits in mask 0x00003E4E can be written. The word at +0x04 always reads 0x00000C20 and ignores writes.
- R10: Each channel's 5-bit `irq_sel` slice is its configuration bits 13:9. While legacy is set, channel 0 selects line 0 and channel 1 selects line 8 instead. `legacy_mode` follows configuration bit 1 from the ack cycle of the write.
- R11: These locations read zero and ignore writes: the status word at 0x020, the message route words at +0x10 and +0x14 of each channel, and any channel window at or above the channel count.
- R12: After reset, the counter is zero, every comparator is all ones, run and legacy are clear, and no `arm` or `cancel` is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance strobe |
| req | input | 1 | Bus request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte address in the 1 KB window |
| wdata | input | 32 | Write data |
| ack | output | 1 | Access complete |
| rdata | output | 32 | Read data, valid with ack |
| count | output | 64 | Live main counter |
| cmp_flat | output | 192 | Comparator values, channel n at bits n*64 and up |
| arm | output | 3 | Per-channel arm strobe |
| cancel | output | 3 | Per-channel cancel strobe |
| irq_sel | output | 15 | Per-channel 5-bit interrupt line number |
| legacy_mode | output | 1 | Legacy routing active |

## Verification
The bench raises a request at a falling edge. The design registers `ack`, `rdata`, `arm`, `cancel` and the configuration at the next rising edge, so all of these results are due in the single cycle after the request. The bench samples them at the following falling edge, halfway through that cycle. Counter results depend on strobes: each `tick` pulse is held across exactly one rising edge, so the expected count is the written value plus the number of pulses given while run was set. `irq_sel` is combinational from registered state, so it is checked in the same sampling slot as the write that changed it.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int REG_W = 32;

  localparam logic [9:0] OFS_CAP_LO  = 10'h000;
  localparam logic [9:0] OFS_CAP_HI  = 10'h004;
  localparam logic [9:0] OFS_GCFG    = 10'h010;
  localparam logic [9:0] OFS_GCFG_HI = 10'h014;
  localparam logic [9:0] OFS_STAT    = 10'h020;
  localparam logic [9:0] OFS_CNT_LO  = 10'h0F0;
  localparam logic [9:0] OFS_CNT_HI  = 10'h0F4;
  localparam logic [9:0] CHAN_BASE   = 10'h100;
  localparam int         CHAN_LG2    = 5;

  typedef enum logic [2:0] {
    SUB_CFG_LO = 3'd0,
    SUB_CFG_HI = 3'd1,
    SUB_CMP_LO = 3'd2,
    SUB_CMP_HI = 3'd3,
    SUB_RTE_LO = 3'd4,
    SUB_RTE_HI = 3'd5
  } chan_sub_e;

  localparam int          ROUTE_LSB   = 9;
  localparam int          ROUTE_W     = 5;
  localparam int          BIT_SETVAL  = 6;
  localparam logic [31:0] CFG_WMASK   = 32'h0000_3E4E;
  localparam logic [31:0] CFG_RESET   = 32'h0000_0030;
  localparam logic [31:0] CAP_ROUTES  = 32'h0000_0C20;

  function automatic logic [31:0] cap_word(input int nch);
    logic [4:0] last;
    last = 5'(nch - 1);
    return {16'h8086, 1'b1, 1'b0, 1'b1, last, 8'h01};
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CW = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [CW/2-1:0]   wdata,
  output logic [CW-1:0]     count
);
  localparam int HALF = CW / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) count[HALF-1:0]  <= wdata;
      if (wr_hi) count[CW-1:HALF] <= wdata;
    end else if (run && tick) begin
      count <= count + CW'(1);
    end
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_lo && !wr_hi) |=> $stable(count)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !wr_lo && !wr_hi) |=> (count == $past(count) + CW'(1))); // R4
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (count[CW-1:HALF] == $past(count[CW-1:HALF]))); // R5
endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cfg,
  input  logic        wr_cmp_lo,
  input  logic        wr_cmp_hi,
  input  logic [31:0] wdata,
  input  logic        glb_en,
  input  logic        glb_rise,
  input  logic        glb_fall,
  output logic [31:0] cfg,
  output logic [63:0] cmp,
  output logic        arm,
  output logic        cancel
);
  logic cmp_wr;
  assign cmp_wr = wr_cmp_lo || wr_cmp_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (wr_cfg) begin
      cfg <= (wdata & CFG_WMASK) | (cfg & ~CFG_WMASK);
    end else if (cmp_wr) begin
      cfg[BIT_SETVAL] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '1;
    end else begin
      if (wr_cmp_lo) cmp[31:0]  <= wdata;
      if (wr_cmp_hi) cmp[63:32] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm    <= 1'b0;
      cancel <= 1'b0;
    end else begin
      arm    <= (glb_rise && (cmp != '1)) || (cmp_wr && glb_en);
      cancel <= glb_fall;
    end
  end

  AST_CANCEL_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    glb_fall |=> (cancel && !arm)); // R7
  AST_RO_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cfg & ~CFG_WMASK) == ($past(cfg) & ~CFG_WMASK))); // R9
  AST_NO_ARM_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !glb_rise) |=> !arm); // R8
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router #(
  parameter int NUM_CH = 3,
  parameter int RW     = 5,
  parameter int LEG0   = 0,
  parameter int LEG1   = 8
) (
  input  logic                 legacy,
  input  logic [NUM_CH*RW-1:0] route_flat,
  output logic [NUM_CH*RW-1:0] irq_sel
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_route
    if (i == 0) begin : g_leg0
      assign irq_sel[i*RW +: RW] = legacy ? RW'(LEG0) : route_flat[i*RW +: RW];
    end else if (i == 1) begin : g_leg1
      assign irq_sel[i*RW +: RW] = legacy ? RW'(LEG1) : route_flat[i*RW +: RW];
    end else begin : g_plain
      assign irq_sel[i*RW +: RW] = route_flat[i*RW +: RW];
    end
  end
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter int          AW      = 10,
  parameter logic [31:0] TICK_FS = 32'd10000000,
  parameter int          LEG0    = 0,
  parameter int          LEG1    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   req,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [31:0]            wdata,
  output logic                   ack,
  output logic [31:0]            rdata,
  output logic [63:0]            count,
  output logic [NUM_CH*64-1:0]   cmp_flat,
  output logic [NUM_CH-1:0]      arm,
  output logic [NUM_CH-1:0]      cancel,
  output logic [NUM_CH*ROUTE_W-1:0] irq_sel,
  output logic                   legacy_mode
);
  localparam int          IDX_W = AW - CHAN_LG2;
  localparam logic [31:0] CAP_LO = cap_word(NUM_CH);

  logic [9:0]       wa;
  logic             wr, in_chan, chan_ok;
  logic [IDX_W-1:0] chan_idx;
  chan_sub_e        sub;
  logic [1:0]       gcfg;
  logic             wr_gcfg, glb_rise, glb_fall;
  logic [31:0]      cfg_arr [NUM_CH];
  logic [63:0]      cmp_arr [NUM_CH];
  logic [NUM_CH*ROUTE_W-1:0] route_flat;
  logic [31:0]      rd_mux;

  assign wa       = {addr[9:2], 2'b00};
  assign wr       = req && we;
  assign in_chan  = wa >= CHAN_BASE;
  assign chan_idx = addr[AW-1:CHAN_LG2] - IDX_W'(CHAN_BASE >> CHAN_LG2);
  assign chan_ok  = in_chan && (int'(chan_idx) < NUM_CH);
  assign sub      = chan_sub_e'(addr[4:2]);

  assign wr_gcfg  = wr && (wa == OFS_GCFG);
  assign glb_rise = wr_gcfg && wdata[0] && !gcfg[0];
  assign glb_fall = wr_gcfg && !wdata[0] && gcfg[0];

  always_ff @(posedge clk) begin
    if (rst) gcfg <= 2'b00;
    else if (wr_gcfg) gcfg <= wdata[1:0];
  end
  assign legacy_mode = gcfg[1];

  evt_main_counter #(.CW(64)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (gcfg[0]),
    .tick (tick),
    .wr_lo(wr && (wa == OFS_CNT_LO)),
    .wr_hi(wr && (wa == OFS_CNT_HI)),
    .wdata(wdata),
    .count(count)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic sel;
    assign sel = wr && chan_ok && (int'(chan_idx) == i);
    evt_chan_regs u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_cfg   (sel && (sub == SUB_CFG_LO)),
      .wr_cmp_lo(sel && (sub == SUB_CMP_LO)),
      .wr_cmp_hi(sel && (sub == SUB_CMP_HI)),
      .wdata    (wdata),
      .glb_en   (gcfg[0]),
      .glb_rise (glb_rise),
      .glb_fall (glb_fall),
      .cfg      (cfg_arr[i]),
      .cmp      (cmp_arr[i]),
      .arm      (arm[i]),
      .cancel   (cancel[i])
    );
    assign cmp_flat[i*64 +: 64]            = cmp_arr[i];
    assign route_flat[i*ROUTE_W +: ROUTE_W] = cfg_arr[i][ROUTE_LSB +: ROUTE_W];
  end

  evt_irq_router #(.NUM_CH(NUM_CH), .RW(ROUTE_W), .LEG0(LEG0), .LEG1(LEG1)) u_rte (
    .legacy    (gcfg[1]),
    .route_flat(route_flat),
    .irq_sel   (irq_sel)
  );

  always_comb begin
    rd_mux = 32'h0;
    if (in_chan) begin
      if (chan_ok) begin
        case (sub)
          SUB_CFG_LO: rd_mux = cfg_arr[chan_idx];
          SUB_CFG_HI: rd_mux = CAP_ROUTES;
          SUB_CMP_LO: rd_mux = cmp_arr[chan_idx][31:0];
          SUB_CMP_HI: rd_mux = cmp_arr[chan_idx][63:32];
          default:    rd_mux = 32'h0;
        endcase
      end
    end else begin
      case (wa)
        OFS_CAP_LO: rd_mux = CAP_LO;
        OFS_CAP_HI: rd_mux = TICK_FS;
        OFS_GCFG:   rd_mux = {30'h0, gcfg};
        OFS_CNT_LO: rd_mux = count[31:0];
        OFS_CNT_HI: rd_mux = count[63:32];
        default:    rd_mux = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= 32'h0;
    end else begin
      ack   <= req;
      rdata <= (req && !we) ? rd_mux : 32'h0;
    end
  end

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> ack); // R1
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ack); // R1
  AST_LEGACY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    wr_gcfg |=> (legacy_mode == $past(wdata[1]))); // R10
  AST_CANCEL_ALL: assert property (@(posedge clk) disable iff (rst)
    glb_fall |=> (cancel == '1)); // R7
endmodule

// File: tb/evt_timer_regs_test.sv
module evt_timer_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ack, legacy_mode;
  logic [31:0] rdata;
  logic [63:0] count;
  logic [NCH*64-1:0] cmp_flat;
  logic [NCH-1:0] arm, cancel;
  logic [NCH*5-1:0] irq_sel;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;
  logic c_ack, c_leg;
  logic [NCH-1:0] c_arm, c_cancel;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer_regs uut (
    .clk(clk), .rst(rst), .tick(tick), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .count(count),
    .cmp_flat(cmp_flat), .arm(arm), .cancel(cancel), .irq_sel(irq_sel),
    .legacy_mode(legacy_mode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    c_ack = ack; c_arm = arm; c_cancel = cancel; c_leg = legacy_mode;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    c_ack = ack; d = rdata;
    @(negedge clk);
    chk("R1 ack lasts one cycle", {63'h0, ack}, 64'h0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R12 arm idle", {61'h0, arm}, 64'h0);
    chk("R12 cancel idle", {61'h0, cancel}, 64'h0);
    chk("R12 count zero", count, 64'h0);
    chk("R12 legacy clear", {63'h0, legacy_mode}, 64'h0);
    bus_rd(10'h108, d); chk("R12 cmp0 lo ones", {32'h0, d}, 64'hFFFF_FFFF);
    chk("R1 read ack", {63'h0, c_ack}, 64'h1);
    bus_rd(10'h14C, d); chk("R12 cmp2 hi ones", {32'h0, d}, 64'hFFFF_FFFF);
    bus_rd(10'h120, d); chk("R9 cfg reset", {32'h0, d}, 64'h30);
  endtask

  task automatic t_capability();
    logic [31:0] d;
    bus_rd(10'h000, d); chk("R2 cap low", {32'h0, d}, 64'h8086_A201);
    bus_rd(10'h004, d); chk("R2 period", {32'h0, d}, 64'h0098_9680);
    bus_wr(10'h000, 32'h1234_5678);
    chk("R1 write ack", {63'h0, c_ack}, 64'h1);
    bus_rd(10'h000, d); chk("R2 cap write ignored", {32'h0, d}, 64'h8086_A201);
  endtask

  task automatic t_gen_config();
    logic [31:0] d;
    bus_wr(10'h010, 32'hFFFF_FFFC);
    bus_rd(10'h010, d); chk("R3 ro bits", {32'h0, d}, 64'h0);
    bus_wr(10'h014, 32'hFFFF_FFFF);
    bus_rd(10'h014, d); chk("R3 upper word", {32'h0, d}, 64'h0);
    bus_rd(10'h010, d); chk("R3 upper write no effect", {32'h0, d}, 64'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(10'h020, 32'hFFFF_FFFF);
    bus_rd(10'h020, d); chk("R11 status", {32'h0, d}, 64'h0);
    bus_wr(10'h110, 32'hFFFF_FFFF);
    bus_rd(10'h110, d); chk("R11 route lo", {32'h0, d}, 64'h0);
    bus_rd(10'h114, d); chk("R11 route hi", {32'h0, d}, 64'h0);
    bus_wr(10'h168, 32'h0000_0001);
    bus_rd(10'h168, d); chk("R11 chan3 cmp", {32'h0, d}, 64'h0);
    bus_rd(10'h160, d); chk("R11 chan3 cfg", {32'h0, d}, 64'h0);
  endtask

  task automatic t_chan_cfg();
    logic [31:0] d;
    bus_wr(10'h100, 32'hFFFF_FFFF);
    bus_rd(10'h100, d); chk("R9 masked cfg", {32'h0, d}, 64'h3E7E);
    bus_wr(10'h108, 32'hFFFF_FFFF);
    chk("R8 no arm while stopped", {61'h0, c_arm}, 64'h0);
    bus_rd(10'h100, d); chk("R8 setval cleared", {32'h0, d}, 64'h3E3E);
    bus_wr(10'h104, 32'h0);
    bus_rd(10'h104, d); chk("R9 cap routes", {32'h0, d}, 64'h0C20);
    bus_wr(10'h100, 32'h0);
    bus_rd(10'h100, d); chk("R9 cleared cfg", {32'h0, d}, 64'h30);
  endtask

  task automatic t_counter();
    logic [31:0] lo, hi;
    bus_wr(10'h0F0, 32'hFFFF_FFF0);
    bus_wr(10'h0F4, 32'h0000_0001);
    ticks(4);
    chk("R4 frozen before run", count, 64'h1_FFFF_FFF0);
    bus_wr(10'h010, 32'h1);
    ticks(20);
    bus_rd(10'h0F0, lo); bus_rd(10'h0F4, hi);
    chk("R4 count after ticks", {hi, lo}, 64'h2_0000_0004);
    bus_wr(10'h010, 32'h0);
    ticks(5);
    bus_rd(10'h0F0, lo); bus_rd(10'h0F4, hi);
    chk("R4 held when stopped", {hi, lo}, 64'h2_0000_0004);
    bus_wr(10'h0F4, 32'h0000_ABCD);
    chk("R5 hi write keeps lo", count, 64'hABCD_0000_0004);
    bus_wr(10'h0F0, 32'h0000_0077);
    chk("R5 lo write keeps hi", count, 64'hABCD_0000_0077);
  endtask

  task automatic t_arm_cancel();
    bus_wr(10'h128, 32'h0000_0100);
    chk("R8 stopped cmp write", {61'h0, c_arm}, 64'h0);
    chk("R8 cmp1 value", cmp_flat[64 +: 64], 64'hFFFF_FFFF_0000_0100);
    bus_wr(10'h010, 32'h1);
    chk("R6 arm only loaded", {61'h0, c_arm}, 64'h2);
    chk("R6 no cancel", {61'h0, c_cancel}, 64'h0);
    @(negedge clk);
    chk("R6 arm one cycle", {61'h0, arm}, 64'h0);
    bus_wr(10'h14C, 32'h0000_0002);
    chk("R8 running cmp write", {61'h0, c_arm}, 64'h4);
    chk("R8 cmp2 value", cmp_flat[128 +: 64], 64'h0000_0002_FFFF_FFFF);
    bus_wr(10'h010, 32'h0);
    chk("R7 cancel all", {61'h0, c_cancel}, 64'h7);
    chk("R7 no arm", {61'h0, c_arm}, 64'h0);
  endtask

  task automatic t_legacy();
    bus_wr(10'h100, 32'h0000_0A00);
    bus_wr(10'h120, 32'h0000_1400);
    bus_wr(10'h140, 32'h0000_1600);
    chk("R10 routes normal", {49'h0, irq_sel}, {49'h0, 5'd11, 5'd10, 5'd5});
    bus_wr(10'h010, 32'h2);
    chk("R10 legacy flag", {63'h0, c_leg}, 64'h1);
    chk("R10 legacy routes", {49'h0, irq_sel}, {49'h0, 5'd11, 5'd8, 5'd0});
    bus_wr(10'h010, 32'h0);
    chk("R10 legacy off", {63'h0, c_leg}, 64'h0);
    chk("R10 routes restored", {49'h0, irq_sel}, {49'h0, 5'd11, 5'd10, 5'd5});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_capability();
    t_gen_config();
    t_unmapped();
    t_chan_cfg();
    t_counter();
    t_arm_cancel();
    t_legacy();
    finish_run();
  end
endmodule